// File: doc/BRIEF.md
# Wake-Up Pin Edge Status Register

This block keeps one sticky flag per general-purpose input pin, recording which pin produced a qualifying transition while the chip was asleep. Each pin comes in asynchronously. It is resynchronized, compared with its previous sampled value, and qualified by three per-pin control inputs: a wake-source enable, a rising-edge enable and a falling-edge enable. A qualified transition sets the pin's flag, and the flag stays set until software clears it.

Software reaches the flags through a single 32-bit register on a simple register bus. A read returns the flags in the low half and zeros in the high half. A write clears every flag whose data bit is one and leaves the others alone. The full hardware reset, the watchdog reset and the GPIO reset each clear every flag. A registered wake request reports whether any flag is set, so the surrounding power controller can act on it.

Top module: `wake_edge_status`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `bus_rdata` and `wake_req` are 0, and a read returns all flags as 0.
- R2: Flag n sets when pin n goes from 0 to 1 and both `wake_en[n]` and `rise_en[n]` are 1. The flag is set at the third rising clock edge after the pin changes.
- R3: Flag n sets when pin n goes from 1 to 0 and both `wake_en[n]` and `fall_en[n]` are 1.
- R4: When both `rise_en[n]` and `fall_en[n]` are 1, a transition in either direction sets flag n.
- R5: A flag never sets while `wake_en[n]` is 0, on a transition whose direction is not enabled, or while the pin holds a steady level.
- R6: A bus write (`bus_en`=1, `bus_we`=1) clears flag n when `bus_wdata[n]` is 1. Flags whose data bit is 0 keep their value.
- R7: When a qualified transition and a write of 1 reach the same flag on the same clock edge, the flag stays set.
- R8: A one-cycle pulse on `wdt_rst` or on `gpio_rst` clears all flags.
- R9: Read data bits [31:16] are always 0. Write data bits [31:16] have no effect. Bit n of the register is the flag of pin n, for n from 0 to 15.
- R10: `wake_req` is the OR of all flags, registered, so it follows them one cycle later.
- R11: A read (`bus_en`=1, `bus_we`=0) loads `bus_rdata` at that clock edge. `bus_rdata` then holds its value until the next read.
- R12: A pin level that is already present when `rst` falls is not reported as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high; clears everything |
| wdt_rst | input | 1 | Watchdog reset, clears the flags |
| gpio_rst | input | 1 | GPIO reset, clears the flags |
| pin_in | input | 16 | Asynchronous pin levels |
| wake_en | input | 16 | Per-pin wake-source enable |
| rise_en | input | 16 | Per-pin rising-transition enable |
| fall_en | input | 16 | Per-pin falling-transition enable |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write-one-to-clear, 0 = read |
| bus_wdata | input | 32 | Write data, clear mask in bits [15:0] |
| bus_rdata | output | 32 | Registered read data |
| wake_req | output | 1 | Registered OR of all flags |

## Verification
A pin change is sampled by two synchronizer flops and then compared with a third flop. A flag therefore sets on the third clock edge after the change. `wake_req` follows one edge after that, and `bus_rdata` is loaded on the edge that sees the read. After every pin change the bench waits four full cycles before it issues a read. It samples on the falling edge after the read edge, so each result is observed only once it is due. The collision test is the one exception. There the bench counts exactly two edges after the pin change, so that the clearing write lands on the same edge as the flag update.

// File: rtl/wake_edge_pkg.sv
package wake_edge_pkg;
  localparam int unsigned PIN_CNT_DEF = 16;
  localparam int unsigned BUS_W_DEF   = 32;
  localparam int unsigned SYNC_DEPTH  = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev,
  output logic         primed
);
  localparam int unsigned FILL_W = STAGES + 1;

  logic [W-1:0]      stage [STAGES];
  logic [FILL_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  // fill marks, stage by stage, which flops hold real samples since reset
  always_ff @(posedge clk) begin
    if (rst) begin
      q_prev <= '0;
      fill   <= '0;
    end else begin
      q_prev <= stage[STAGES-1];
      fill   <= {fill[FILL_W-2:0], 1'b1};
    end
  end

  assign q      = stage[STAGES-1];
  assign primed = fill[FILL_W-1];
endmodule

// File: rtl/edge_qualify.sv
module edge_qualify
  import wake_edge_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         primed,
  input  logic [W-1:0] wake_en,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] set_mask
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    edge_pair_t ev;
    assign ev.rise    = cur[g] & ~prev[g];
    assign ev.fall    = ~cur[g] & prev[g];
    assign set_mask[g] = primed & wake_en[g] &
                         ((rise_en[g] & ev.rise) | (fall_en[g] & ev.fall));
  end
endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         side_clr,
  input  logic [W-1:0] set_mask,
  input  logic         clr_valid,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_valid ? clr_mask : '0;

  // a new edge is ORed in after the clear, so it wins the collision
  always_ff @(posedge clk) begin
    if (rst || side_clr) status <= '0;
    else                 status <= (status & ~clr_eff) | set_mask;
  end
endmodule

// File: rtl/wake_edge_status.sv
module wake_edge_status
  import wake_edge_pkg::*;
#(
  parameter int unsigned PIN_CNT = PIN_CNT_DEF,
  parameter int unsigned BUS_W   = BUS_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wdt_rst,
  input  logic               gpio_rst,
  input  logic [PIN_CNT-1:0] pin_in,
  input  logic [PIN_CNT-1:0] wake_en,
  input  logic [PIN_CNT-1:0] rise_en,
  input  logic [PIN_CNT-1:0] fall_en,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               wake_req
);
  localparam int unsigned RSV_W = BUS_W - PIN_CNT;

  logic [PIN_CNT-1:0] pin_cur, pin_prev, set_mask, status_q;
  logic               primed, wr_hit, rd_hit;
  logic [RSV_W-1:0]   wdata_rsv_unused;

  assign wr_hit           = bus_en & bus_we;
  assign rd_hit           = bus_en & ~bus_we;
  assign wdata_rsv_unused = bus_wdata[BUS_W-1:PIN_CNT];

  pin_sync #(.W(PIN_CNT), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in),
    .q(pin_cur), .q_prev(pin_prev), .primed(primed)
  );

  edge_qualify #(.W(PIN_CNT)) u_qual (
    .cur(pin_cur), .prev(pin_prev), .primed(primed),
    .wake_en(wake_en), .rise_en(rise_en), .fall_en(fall_en),
    .set_mask(set_mask)
  );

  status_bank #(.W(PIN_CNT)) u_bank (
    .clk(clk), .rst(rst), .side_clr(wdt_rst | gpio_rst),
    .set_mask(set_mask), .clr_valid(wr_hit),
    .clr_mask(bus_wdata[PIN_CNT-1:0]), .status(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      wake_req  <= 1'b0;
    end else begin
      wake_req <= |status_q;
      if (rd_hit) bus_rdata <= {{RSV_W{1'b0}}, status_q};
    end
  end
endmodule

// File: rtl/wake_edge_status_chk.sv
module wake_edge_status_chk #(
  parameter int unsigned PIN_CNT = 16,
  parameter int unsigned BUS_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               wdt_rst,
  input logic               gpio_rst,
  input logic [PIN_CNT-1:0] wake_en,
  input logic               bus_en,
  input logic               bus_we,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               wake_req,
  input logic [PIN_CNT-1:0] status
);
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:PIN_CNT] == '0); // R9

  AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wake_req == (|$past(status)))); // R10

  AST_SIDE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst || gpio_rst) |=> (status == '0)); // R8

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(wake_en)) == '0)); // R5

  AST_UNWRITTEN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && !wdt_rst && !gpio_rst) |=>
    (($past(status) & ~$past(bus_wdata[PIN_CNT-1:0]) & ~status) == '0)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata)); // R11
endmodule

bind wake_edge_status wake_edge_status_chk #(.PIN_CNT(PIN_CNT), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
  .wake_en(wake_en), .bus_en(bus_en), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req),
  .status(status_q)
);

// File: tb/test_wake_edge_status.sv
module test_wake_edge_status;
  localparam int unsigned NP = 16;
  localparam int unsigned BW = 32;
  localparam int unsigned NV = 11;

  typedef struct packed {
    logic [15:0] pins;
    logic [15:0] wen;
    logic [15:0] ren;
    logic [15:0] fen;
    logic [31:0] clr;
    logic [15:0] exp;
  } vec_t;

  // walked in order; each row starts from the flags the previous row left
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 32'h0,          16'h0000},
    '{16'h000F, 16'h0005, 16'hFFFF, 16'h0000, 32'h0,          16'h0005},
    '{16'h000F, 16'hFFFF, 16'hFFFF, 16'h0000, 32'h0,          16'h0005},
    '{16'h000F, 16'hFFFF, 16'hFFFF, 16'h0000, 32'h00000001,   16'h0004},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 32'h0,          16'h0004},
    '{16'h00F0, 16'hFFFF, 16'h0000, 16'hFFFF, 32'h0,          16'h0004},
    '{16'h0000, 16'hFFFF, 16'h0000, 16'h0030, 32'h0,          16'h0034},
    '{16'hF000, 16'hFFFF, 16'hF000, 16'hF000, 32'h0,          16'hF034},
    '{16'h0000, 16'hFFFF, 16'hF000, 16'hF000, 32'hFFFF0000,   16'hF034},
    '{16'h0100, 16'h0000, 16'h0100, 16'h0000, 32'h0000F000,   16'h0034},
    '{16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 32'hFFFFFFFF,   16'h0000}
  };
  localparam string VTAG [NV] = '{"R5", "R2", "R5", "R6", "R5", "R5",
                                  "R3", "R4", "R9", "R6", "R6"};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wdt_rst = 1'b0;
  logic          gpio_rst = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] wake_en = '0;
  logic [NP-1:0] rise_en = '0;
  logic [NP-1:0] fall_en = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          wake_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wake_edge_status #(.PIN_CNT(NP), .BUS_W(BW)) i_wake_edge_status (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
    .pin_in(pin_in), .wake_en(wake_en), .rise_en(rise_en), .fall_en(fall_en),
    .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_clear(input logic [31:0] mask);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_wdata = mask;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read();
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    chk("R1 wake in reset", {31'h0, wake_req}, 32'h0);
    rst = 1'b0;
    bus_read();
    chk("R1 read after reset", bus_rdata, 32'h0);
    chk("R1 wake after reset", {31'h0, wake_req}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pin_in = VECS[v].pins; wake_en = VECS[v].wen;
      rise_en = VECS[v].ren;  fall_en = VECS[v].fen;
      repeat (4) @(negedge clk);
      if (VECS[v].clr != 32'h0) bus_clear(VECS[v].clr);
      bus_read();
      chk(VTAG[v], bus_rdata, {16'h0, VECS[v].exp});
    end

    // R10: wake request from a fresh flag, then R7 collision on the same flag
    @(negedge clk);
    wake_en = 16'h0200; rise_en = 16'h0200; fall_en = 16'h0200;
    pin_in = 16'h0200;
    repeat (4) @(negedge clk);
    chk("R10 wake high", {31'h0, wake_req}, 32'h1);
    pin_in = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_wdata = 32'h0000_0200;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    bus_read();
    chk("R7 edge beats clear", bus_rdata, 32'h0000_0200);

    // R8 watchdog reset
    @(negedge clk); wdt_rst = 1'b1;
    @(negedge clk); wdt_rst = 1'b0;
    bus_read();
    chk("R8 watchdog clear", bus_rdata, 32'h0);
    chk("R10 wake low", {31'h0, wake_req}, 32'h0);

    // R8 GPIO reset
    pin_in = 16'h0200;
    repeat (4) @(negedge clk);
    bus_read();
    chk("R2 set again", bus_rdata, 32'h0000_0200);
    @(negedge clk); gpio_rst = 1'b1;
    @(negedge clk); gpio_rst = 1'b0;
    bus_read();
    chk("R8 gpio clear", bus_rdata, 32'h0);

    // R12: pins high across the hardware reset
    @(negedge clk);
    rst = 1'b1; pin_in = 16'hFFFF;
    wake_en = 16'hFFFF; rise_en = 16'hFFFF; fall_en = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    bus_read();
    chk("R12 no edge from reset level", bus_rdata, 32'h0);
    chk("R12 wake stays low", {31'h0, wake_req}, 32'h0);

    // R11: rdata holds across a later flag change without a read
    pin_in = 16'h7FFF;
    repeat (4) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 32'h0);
    bus_read();
    chk("R11 rdata updated", bus_rdata, 32'h0000_8000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule